// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the timing pulses that drive a serial port's receiver and transmitter from a fixed 100 MHz system clock. It does not divide by an integer. A 16-bit phase accumulator adds a programmable increment on every clock cycle. Each wrap of the accumulator produces one pulse of the 16x oversampling tick. The tick rate is therefore f_clk × increment / 2^16. Setting the increment to baud × 2^20 / f_clk gives sixteen ticks per bit period. The same formula is baud × 4096 × 256 / 10^8 when the clock is 100 MHz. This gives nearly any baud rate up to f_clk/16. The configured rate can be read back as increment × 10^8 / 2^20.

Software loads the increment as two byte halves through separate write strobes that share one data byte. While the port is running, a write to the upper half is only staged, and the lower-half write moves the whole pair into the active increment at once. A half-updated rate is therefore never used. While the port is disabled, either half goes straight into the active increment. Clearing the enable zeroes the accumulator, so every enable starts from a known phase. An optional divider counts sixteen oversampling ticks and produces a 1x bit tick.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both tick outputs are low and the active increment is zero.
- R2: While enabled with increment I, the number of 16x ticks in the first N cycles after enable is floor(N × I / 2^16). Each tick appears one cycle after the accumulator add that wraps.
- R3: An active increment of zero produces no 16x tick and no bit tick.
- R4: While enabled, a write to the upper byte alone leaves the rate unchanged. The next lower-byte write makes the active increment {staged upper byte, written lower byte}.
- R5: While disabled, an upper-byte write replaces bits 15:8 of the active increment directly, and a lower-byte write sets the active increment to {upper byte, data}.
- R6: While the enable is low, both tick outputs stay low and the accumulator and bit divider are held at zero. After re-enable, counting restarts from phase zero.
- R7: The bit tick pulses on every 16th 16x tick, counted from enable, in the same cycle as that 16x tick. With increment 0x1000, the first bit tick comes 256 cycles after enable.
- R8: When both byte strobes are asserted in the same cycle, the data byte is used for both halves, so the active increment becomes {data, data}.
- R9: Increment 0xFFFF gives a tick in every cycle except one per 65536. The first 64 cycles after enable hold 63 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low holds the accumulator and divider at zero |
| wr_hi | input | 1 | Write strobe for the upper increment byte |
| wr_lo | input | 1 | Write strobe for the lower increment byte (commits the pair) |
| wr_data | input | 8 | Byte written by either strobe |
| tick_os | output | 1 | One-cycle 16x oversampling tick |
| tick_bit | output | 1 | One-cycle 1x bit tick |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator, 8-bit byte halves, an oversampling ratio of 16 and the bit divider present. With these values, extreme increments such as 0xFFFF and 0x8000 give exact tick counts in short windows. Increment 0x1000 reaches the first bit tick at exactly cycle 256. A cycle-by-cycle predictor follows the staging and direct-write rules and compares both ticks in every cycle. This covers writes made while the accumulator is mid-phase.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int unsigned BYTE_W_DEF = 8;
   localparam int unsigned OS_RATIO_DEF = 16;

   typedef enum logic [1:0] {
      WR_NONE = 2'b00,
      WR_LO   = 2'b01,
      WR_HI   = 2'b10,
      WR_BOTH = 2'b11
   } wr_kind_e;
endpackage

// File: rtl/baud_inc_shadow.sv
module baud_inc_shadow
   import baud_pkg::*;
#(
   parameter int unsigned BYTE_W = BYTE_W_DEF,
   localparam int unsigned INC_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [INC_W-1:0]  inc_o
);
   logic [BYTE_W-1:0] hold_q, hold_nxt;
   logic [INC_W-1:0]  inc_q;
   wr_kind_e          kind;

   assign kind     = wr_kind_e'({wr_hi, wr_lo});
   assign hold_nxt = wr_hi ? wr_data : hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         inc_q  <= '0;
      end else begin
         hold_q <= hold_nxt;
         case (kind)
            WR_LO, WR_BOTH: inc_q <= {hold_nxt, wr_data};
            WR_HI: if (!enable) inc_q[INC_W-1:BYTE_W] <= wr_data;
            default: ;
         endcase
      end
   end

   assign inc_o = inc_q;

   a_r4_staged_hi_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && wr_hi && !wr_lo) |=> $stable(inc_o));
   a_r5_direct_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && wr_hi && !wr_lo) |=> (inc_o[INC_W-1:BYTE_W] == $past(wr_data)));
   a_r8_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && wr_lo) |=> (inc_o == {$past(wr_data), $past(wr_data)}));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [ACC_W-1:0] inc_i,
   output logic             wrap_o,
   output logic             tick_o
);
   if (ACC_W < 2) begin : g_bad_width
      $error("baud_phase_acc: ACC_W must be at least 2");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
   assign wrap_o = enable & sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else if (!enable) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         acc_q  <= sum[ACC_W-1:0];
         tick_o <= sum[ACC_W];
      end
   end

   a_r3_zero_inc_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && inc_i == '0) |=> !tick_o);
   a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!tick_o && acc_q == '0));
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
   parameter int unsigned RATIO = 16,
   parameter bit          EN    = 1'b1,
   localparam int unsigned CNT_W = (RATIO > 2) ? $clog2(RATIO) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic step_i,
   output logic tick_o
);
   if (RATIO < 2) begin : g_bad_ratio
      $error("baud_bit_div: RATIO must be at least 2");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

   if (EN) begin : g_div
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
         end else if (!enable) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
         end else begin
            tick_o <= step_i && (cnt_q == LAST);
            if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
      a_r7_bit_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |-> $past(step_i));
   end else begin : g_nodiv
      assign tick_o = 1'b0;
   end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int unsigned BYTE_W      = BYTE_W_DEF,
   parameter int unsigned OS_RATIO    = OS_RATIO_DEF,
   parameter bit          BIT_TICK_EN = 1'b1,
   localparam int unsigned INC_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick_os,
   output logic              tick_bit
);
   if (BYTE_W < 2) begin : g_bad_byte
      $error("baud_tick_gen: BYTE_W must be at least 2");
   end

   logic [INC_W-1:0] inc;
   logic             wrap;

   baud_inc_shadow #(.BYTE_W(BYTE_W)) i_shadow (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .inc_o(inc)
   );

   baud_phase_acc #(.ACC_W(INC_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .inc_i(inc), .wrap_o(wrap), .tick_o(tick_os)
   );

   baud_bit_div #(.RATIO(OS_RATIO), .EN(BIT_TICK_EN)) i_div (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .step_i(wrap), .tick_o(tick_bit)
   );

   a_r7_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
      tick_bit |-> tick_os);
   a_r6_low_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!tick_os && !tick_bit));
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick_os, tick_bit;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   baud_tick_gen i_baud_tick_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_hi(wr_hi), .wr_lo(wr_lo),
      .wr_data(wr_data), .tick_os(tick_os), .tick_bit(tick_bit)
   );

   // Predictor: builds expected outputs from the requirements and queues them
   logic [1:0]  exp_q[$];
   logic [7:0]  m_hold = '0;
   logic [15:0] m_inc = '0;
   logic [15:0] m_acc = '0;
   int          m_cnt = 0;

   always @(posedge clk) begin
      logic [16:0] s;
      logic        e_os, e_bit;
      e_os = 1'b0;
      e_bit = 1'b0;
      if (!rst_n) begin
         m_hold = '0; m_inc = '0; m_acc = '0; m_cnt = 0;
      end else begin
         if (!enable) begin
            m_acc = '0; m_cnt = 0;
         end else begin
            s = {1'b0, m_acc} + {1'b0, m_inc};
            m_acc = s[15:0];
            e_os = s[16];
            if (e_os) begin
               e_bit = (m_cnt == 15);
               m_cnt = (m_cnt + 1) % 16;
            end
         end
         if (wr_hi) m_hold = wr_data;
         if (wr_lo) m_inc = {m_hold, wr_data};
         else if (wr_hi && !enable) m_inc[15:8] = wr_data;
      end
      exp_q.push_back({e_os, e_bit});
   end

   // Monitor: pops and compares away from the active edge
   always @(negedge clk) begin
      logic [1:0] e;
      if (exp_q.size() > 0 && !done) begin
         e = exp_q.pop_front();
         checks++;
         if (tick_os !== e[1]) begin
            failures++;
            $display("FAIL R2 tick_os actual=%b expected=%b at %0t", tick_os, e[1], $time);
         end
         checks++;
         if (tick_bit !== e[0]) begin
            failures++;
            $display("FAIL R7 tick_bit actual=%b expected=%b at %0t", tick_bit, e[0], $time);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit hi, input bit lo, input logic [7:0] d);
      @(negedge clk);
      wr_hi = hi; wr_lo = lo; wr_data = d;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0;
   endtask

   task automatic set_en(input bit v);
      @(negedge clk);
      enable = v;
   endtask

   task automatic count(input int n, output int os, output int bt);
      os = 0; bt = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         os += int'(tick_os);
         bt += int'(tick_bit);
      end
   endtask

   initial begin
      int os, bt;
      repeat (3) @(negedge clk);
      check("R1 reset tick_os", int'(tick_os), 0);
      check("R1 reset tick_bit", int'(tick_bit), 0);
      rst_n = 1'b1;

      // R1 and R3: increment after reset is zero, no ticks
      set_en(1'b1);
      count(50, os, bt);
      check("R3 zero inc os", os, 0);
      check("R1 zero inc bit", bt, 0);

      // R5: direct writes while disabled, then R2/R7 rate
      set_en(1'b0);
      wr(1, 0, 8'h10);
      wr(0, 1, 8'h00);
      set_en(1'b1);
      count(255, os, bt);
      check("R7 no bit tick before 256", bt, 0);
      count(1, os, bt);
      check("R7 bit tick at cycle 256", bt, 1);

      // R4: staged upper byte keeps the rate
      wr(1, 0, 8'h80);
      count(256, os, bt);
      check("R4 staged hi keeps rate", os, 16);
      wr(0, 1, 8'h00);
      count(64, os, bt);
      check("R4 commit 0x8000 rate", os, 32);

      // R6: quiet while disabled
      set_en(1'b0);
      count(5, os, bt);
      check("R6 os low while disabled", os, 0);
      check("R6 bit low while disabled", bt, 0);

      // R9 and R6: max increment from phase zero
      wr(1, 0, 8'hFF);
      wr(0, 1, 8'hFF);
      set_en(1'b1);
      count(64, os, bt);
      check("R9 0xFFFF first 64 cycles", os, 63);

      // R8: both strobes together
      set_en(1'b0);
      wr(1, 1, 8'h20);
      set_en(1'b1);
      count(64, os, bt);
      check("R8 inc 0x2020 count", os, 8);

      // R2: 0x8000 from zero, with R7 bit ticks
      set_en(1'b0);
      wr(1, 0, 8'h80);
      wr(0, 1, 8'h00);
      set_en(1'b1);
      count(512, os, bt);
      check("R2 inc 0x8000 os count", os, 256);
      check("R7 inc 0x8000 bit count", bt, 16);

      // R5: upper-byte direct write while disabled keeps lower byte
      set_en(1'b0);
      wr(1, 0, 8'h40);
      set_en(1'b1);
      count(64, os, bt);
      check("R5 direct hi gives 0x4000", os, 16);

      // R3: back to zero
      set_en(1'b0);
      wr(1, 0, 8'h00);
      wr(0, 1, 8'h00);
      set_en(1'b1);
      count(100, os, bt);
      check("R3 zero inc after use", os, 0);
      check("R3 zero inc bit", bt, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule